// File: doc/BRIEF.md
# Parallel EEPROM Byte Writer with Completion Polling

This block runs on the host side of a byte-wide parallel EEPROM. It takes a single request through a valid signal, a read/write select, an address and a byte. For a write it produces a chip-enable, write-enable and output-enable sequence with programmable setup, strobe and hold lengths. It then reads the same location again and again until the device reports that its internal programming has finished. For a read it makes one timed access and returns the byte.

The memory inverts the most significant data bit (bit 7) during a read while a write is still being programmed. The engine uses this to detect completion. After the strobe it alternates a short deselected gap with a timed read. Each read compares returned bit 7 with bit 7 of the byte that was written. A match ends the operation with a one-cycle `done`. If the polling phase lasts longer than a timeout, the engine gives a one-cycle `err` and returns to idle. The timeout is a parameter multiple of the nominal programming time. The data pins of the memory are left to the integration level. The engine provides separate outgoing data, incoming data and a drive-enable.

Top module: `eeprom_write_poll`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe`, `done` and `err` are low, and `req_ready` is high.
- R2: A write keeps `mem_ce_n` low throughout. `mem_we_n` is low for exactly PULSE_CYC cycles. That pulse is preceded by exactly SETUP_CYC cycles and followed by exactly HOLD_CYC cycles with `mem_ce_n` low and `mem_we_n` high. `mem_oe_n` stays high while `mem_we_n` is low.
- R3: `mem_dq_oe` is high for every cycle that `mem_we_n` is low, and for the hold cycles after it. It is never high while `mem_oe_n` is low.
- R4: A poll or plain read drives `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for ACCESS_CYC cycles. The engine samples `mem_din` in the last of these cycles.
- R5: After a write, consecutive accesses are separated by exactly GAP_CYC cycles with `mem_ce_n` and `mem_oe_n` high. A poll whose bit 7 is the inverse of written bit 7 leads to another gap and poll.
- R6: A poll whose bit 7 equals written bit 7 ends the write. `done` is then high for one cycle, and no further poll follows.
- R7: `req_ready` is low from the cycle after a request is accepted until the operation ends. A request presented in that window is ignored and writes nothing.
- R8: If the polling phase lasts WRITE_CYC*TIMEOUT_MULT cycles without a match, `err` is high for one cycle, `done` stays low, and the engine returns to idle.
- R9: A plain read ends with `done` high for one cycle. `rd_data` then holds the byte sampled in the last access cycle.
- R10: `mem_addr` holds the accepted address without change for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = byte write with polling, 0 = plain read |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Byte to write |
| req_ready | output | 1 | Engine idle, request will be taken |
| done | output | 1 | One-cycle pulse: operation finished |
| err | output | 1 | One-cycle pulse: polling timed out |
| rd_data | output | DATA_W | Byte returned by the last plain read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Byte toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_din | input | DATA_W | Byte from the memory |

## Verification
The bench builds the engine with SETUP_CYC=2, PULSE_CYC=3, HOLD_CYC=1, ACCESS_CYC=2 and GAP_CYC=1. These are all distinct short lengths, so a phase that runs one cycle long or short shows up in the measured strobe widths. WRITE_CYC=40 with TIMEOUT_MULT=2 sets an 80-cycle polling limit. A memory model that stays busy for 30 cycles therefore completes after about ten polls. A model busy for one cycle completes at the first poll. A model stuck busy reaches the timeout within a few hundred cycles.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_PGAP,
    ST_PREAD,
    ST_RREAD
  } eewp_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eewp_phase_timer.sv
module eewp_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eewp_poll_watchdog.sv
module eewp_poll_watchdog #(
  parameter int LIMIT = 600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/eeprom_write_poll.sv
module eeprom_write_poll
  import eewp_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int SETUP_CYC    = 1,
  parameter int PULSE_CYC    = 5,
  parameter int HOLD_CYC     = 1,
  parameter int ACCESS_CYC   = 13,
  parameter int GAP_CYC      = 1,
  parameter int WRITE_CYC    = 150000,
  parameter int TIMEOUT_MULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int PH_MAX  = imax(imax(imax(SETUP_CYC, PULSE_CYC), imax(HOLD_CYC, ACCESS_CYC)), GAP_CYC);
  localparam int TMR_W   = $clog2(PH_MAX + 1);
  localparam int TMO_CYC = WRITE_CYC * TIMEOUT_MULT;
  localparam int MSB     = DATA_W - 1;

  eewp_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rd_q;
  logic              done_q, done_d, err_q, err_d;
  logic              accept, rd_capture;
  logic              tmr_load, tmr_exp, wd_exp, wd_run, wd_clr;
  logic [TMR_W-1:0]  tmr_val;
  logic              poll_match;

  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign poll_match = (mem_din[MSB] == data_q[MSB]);

  // next-state process
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    rd_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WSETUP;
          tmr_val = TMR_W'(SETUP_CYC - 1);
        end else begin
          state_d = ST_RREAD;
          tmr_val = TMR_W'(ACCESS_CYC - 1);
        end
      end
      ST_WSETUP: if (tmr_exp) begin
        state_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = TMR_W'(PULSE_CYC - 1);
      end
      ST_WPULSE: if (tmr_exp) begin
        state_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (tmr_exp) begin
        state_d = ST_PGAP; tmr_load = 1'b1; tmr_val = TMR_W'(GAP_CYC - 1);
      end
      ST_PGAP: begin
        if (wd_exp) begin
          state_d = ST_IDLE; err_d = 1'b1;
        end else if (tmr_exp) begin
          state_d = ST_PREAD; tmr_load = 1'b1; tmr_val = TMR_W'(ACCESS_CYC - 1);
        end
      end
      ST_PREAD: begin
        if (tmr_exp && poll_match) begin
          state_d = ST_IDLE; done_d = 1'b1;
        end else if (wd_exp) begin
          state_d = ST_IDLE; err_d = 1'b1;
        end else if (tmr_exp) begin
          state_d = ST_PGAP; tmr_load = 1'b1; tmr_val = TMR_W'(GAP_CYC - 1);
        end
      end
      ST_RREAD: if (tmr_exp) begin
        state_d = ST_IDLE; done_d = 1'b1; rd_capture = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (rd_capture) rd_q <= mem_din;
    end
  end

  assign wd_run = (state_q == ST_PGAP) || (state_q == ST_PREAD);
  assign wd_clr = !wd_run;

  eewp_phase_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  eewp_poll_watchdog #(.LIMIT(TMO_CYC)) u_wd (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .run(wd_run), .expired(wd_exp)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rd_data   = rd_q;
  assign mem_ce_n  = (state_q == ST_IDLE) || (state_q == ST_PGAP);
  assign mem_we_n  = (state_q != ST_WPULSE);
  assign mem_oe_n  = !((state_q == ST_PREAD) || (state_q == ST_RREAD));
  assign mem_dq_oe = (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  assign mem_addr  = addr_q;
  assign mem_dout  = data_q;
endmodule

// File: rtl/eewp_checker.sv
module eewp_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  p_drive_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_drive_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));
endmodule

bind eeprom_write_poll eewp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err(err), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/eeprom_write_poll_tb.sv
module eeprom_write_poll_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11, DW = 8;
  localparam int SETUP = 2, PULSE = 3, HOLD = 1, ACCESS = 2, GAP = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, err, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_write_poll #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
    .HOLD_CYC(HOLD), .ACCESS_CYC(ACCESS), .GAP_CYC(GAP), .WRITE_CYC(40), .TIMEOUT_MULT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready), .done(done),
    .err(err), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dq_oe(mem_dq_oe), .mem_din(mem_din));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: bit 7 reads inverted while busy
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] wbyte = '0;
  int busy = 0, busy_len = 30;
  bit stuck = 0;
  logic we_prev = 1'b1;

  always @(posedge clk) begin
    if (we_prev == 1'b0 && mem_we_n && !mem_ce_n) begin
      check(mem_dq_oe == 1'b1, "R3 drive at strobe end", mem_dq_oe, 1);
      mem[mem_addr] <= mem_dout;
      wbyte <= mem_dout;
      busy  <= busy_len;
    end else if (busy != 0 && !stuck) busy <= busy - 1;
    we_prev <= mem_we_n;
  end

  assign mem_din = (!mem_ce_n && !mem_oe_n) ?
                   ((busy != 0) ? {~wbyte[7], 7'h2A} : mem[mem_addr]) : 8'h00;

  // scoreboard
  typedef struct packed { bit is_err; bit chk_data; logic [DW-1:0] data; } exp_t;
  exp_t sb[$];
  int polls = 0;
  int wl = 0, pre = 0, hc = 0, gc = 0;
  logic oe_prev = 1'b1;

  always @(negedge clk) if (rst_n) begin
    // R2 strobe widths
    if (!mem_we_n) begin
      if (pre != 0) check(pre == SETUP, "R2 setup cycles", pre, SETUP);
      pre = 0; wl++;
    end else begin
      if (wl != 0) check(wl == PULSE, "R2 pulse cycles", wl, PULSE);
      wl = 0;
      if (!mem_ce_n && mem_oe_n && !mem_dq_oe) pre++; else pre = 0;
    end
    if (!mem_ce_n && mem_we_n && mem_dq_oe) hc++;
    if (mem_ce_n) begin
      if (hc != 0) check(hc == HOLD, "R2 hold cycles", hc, HOLD);
      hc = 0;
    end
    if (mem_dq_oe && !mem_oe_n) check(0, "R3 drive during read", 1, 0);
    // R5 gap between accesses
    if (mem_ce_n && !req_ready) gc++;
    else if (!mem_ce_n && gc != 0) begin
      check(gc == GAP, "R5 gap cycles", gc, GAP);
      check(!mem_oe_n, "R4 access after gap", mem_oe_n, 0);
      gc = 0;
    end
    if (req_ready) gc = 0;
    if (!mem_oe_n && oe_prev) polls++;
    oe_prev = mem_oe_n;
    // outcome compare
    if (done || err) begin
      if (sb.size() == 0) check(0, "R6 unexpected end", {done, err}, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(err == e.is_err && done == !e.is_err, e.is_err ? "R8 outcome" : "R6 outcome",
              {done, err}, e.is_err ? 1 : 2);
        if (done && !e.chk_data) check(busy == 0, "R6 done only after programming", busy, 0);
        if (e.chk_data) check(rd_data == e.data, "R9 read data", rd_data, e.data);
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    polls = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R7 ready drops after accept", req_ready, 0);
    check(mem_addr == a, "R10 address presented", mem_addr, a);
  endtask

  task automatic wait_end();
    while (!(done || err)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp_err);
    exp_t e;
    e.is_err = exp_err; e.chk_data = 0; e.data = d;
    sb.push_back(e);
    issue(1, a, d);
    wait_end();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    e.is_err = 0; e.chk_data = 1; e.data = d;
    sb.push_back(e);
    issue(0, a, d);
    wait_end();
    check(polls == 1, "R4 single read access", polls, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = i[7:0];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe && !done && !err, "R1 flags low", {mem_dq_oe, done, err}, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && mem_ce_n, "R1 idle after release", req_ready, 1);

    // write with bit7 set, programming lasts 30 cycles
    do_write(11'h123, 8'hA5, 0);
    check(polls > 1, "R5 repeated polling while busy", polls, 2);
    do_read(11'h123, 8'hA5);

    // stray request during polling must be ignored (R7)
    begin
      exp_t e;
      e.is_err = 0; e.chk_data = 0; e.data = 8'h3C;
      sb.push_back(e);
      issue(1, 11'h7FF, 8'h3C);
      while (mem_oe_n) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 11'h7FF; req_data = 8'hC3;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!req_ready, "R7 busy while polling", req_ready, 0);
        check(mem_addr == 11'h7FF && mem_dout == 8'h3C, "R10 operands held", mem_dout, 8'h3C);
      end
      req_valid = 0;
      wait_end();
    end
    do_read(11'h7FF, 8'h3C);

    // programming done before first poll: completes at first poll
    busy_len = 1;
    do_write(11'h000, 8'h80, 0);
    check(polls == 1, "R6 completion on first poll", polls, 1);
    do_read(11'h000, 8'h80);
    do_write(11'h001, 8'h7F, 0);
    check(polls == 1, "R6 bit7 clear completion", polls, 1);

    // device stuck busy: timeout
    busy_len = 30;
    stuck = 1;
    do_write(11'h010, 8'h11, 1);
    check(polls > 20, "R8 polled until timeout", polls, 21);
    check(req_ready, "R8 back to idle", req_ready, 1);
    stuck = 0;
    repeat (40) @(negedge clk);
    do_read(11'h010, 8'h11);
    do_read(11'h055, 8'h55);
    check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule